// File: doc/BRIEF.md
# SDRAM Read-to-Write Interrupt Sequencer

This block turns single requests from a host port into burst commands for one bank of an SDR SDRAM. A read request issues a READ with four data beats. A write request issues a WRITE, and the controller drives four data beats starting in the command cycle. The bank is assumed to be open already. Row activation, precharge, refresh and initialization are handled elsewhere.

A write can arrive while a read burst is still in flight. If there is still time, the sequencer cuts the read short. It raises the data mask for three cycles so that the memory's outputs go to high impedance, and then presents the WRITE. The CAS latency is programmable to 1, 2 or 3. It fixes both when read data shows up and which read beats survive the mask. Read beats that the mask suppressed are never reported to the host. If the write comes too late to gain anything, it waits for the read to finish and for one turnaround cycle.

The memory data bus is exposed as three plain signals: a data input, a data output and an output enable. The tri-state pad is left to the chip top.

Top module: `sdr_rw_seq`

## Requirements
- R1: While reset is held, and after it is released, the pins carry NOP, the mask is low, the output enable is low, no read beat is reported and req_ready is high.
- R2: Only three command encodings appear on (cs_n, ras_n, cas_n, we_n): NOP = 0,1,1,1; READ = 0,1,0,1; WRITE = 0,1,0,0. A request accepted on one clock edge puts its command on the pins in the next cycle, with its address on sd_addr. sd_addr is zero on NOP cycles.
- R3: With CAS latency L, which is sampled when the read is accepted (a value of 0 acts as 1), read beat i (0..3) is taken from dq_in in READ cycle + L + i. It is reported one cycle later with rd_valid high and rd_beat = i. An uninterrupted read reports all four beats.
- R4: A write accepted at the end of READ cycle + d, with d <= L, raises sd_dqm in cycles READ+d+1 through READ+d+3 and issues the WRITE in cycle READ+d+4.
- R5: sd_dqm is low in every WRITE cycle and in every cycle outside the window of R4.
- R6: When a read is cut short as in R4, only beats i < d+3-L (clamped at 0) are reported. Later beats are discarded.
- R7: A write accepted at the end of READ cycle + d, with L+1 <= d <= L+3, issues the WRITE in cycle READ+L+5 and never raises sd_dqm.
- R8: From the WRITE cycle, dq_oe is high for exactly four cycles. Beat b is req_wdata[b*DW +: DW], so beat 0 is in the low bits.
- R9: dq_oe is never high in a cycle in which the memory could drive unmasked read data. No read beat is reported that was sampled while dq_oe was high.
- R10: req_ready is high in idle. During a read it is high only for a write, only while no write is already held, and only before READ cycle + L + 4. It is low during a write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat | input | 2 | CAS latency (1..3), sampled when a read is accepted |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Column address of the request |
| req_wdata | input | 4*DW | Write burst, beat 0 in the low bits |
| req_ready | output | 1 | Request accepted on this edge when req_valid is high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | AW | Address for READ/WRITE, zero otherwise |
| sd_dqm | output | 1 | Data mask toward the memory |
| dq_in | input | DW | Data bus as seen from the memory |
| dq_out | output | DW | Write data toward the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| rd_valid | output | 1 | A read beat is presented to the host |
| rd_beat | output | 2 | Index of the presented beat |
| rd_data | output | DW | Presented read beat |

## Verification
Two duties can meet on the same edge: raising the mask for a write that is waiting, and capturing a read beat that is still arriving. The mask also silences beats two cycles after it rises. To bring them together, the bench sweeps the arrival cycle of the write across the whole read burst for every CAS latency, from the READ cycle itself to past the turnaround. For each case it works out the WRITE cycle, the mask window and the number of surviving beats. It then compares every cycle of the pins and of the host read outputs against that schedule. It also flags any cycle in which the output enable overlaps a beat that the memory could still be driving.

// File: rtl/sdr_rw_pkg.sv
package sdr_rw_pkg;
   localparam int BEATS  = 4;
   localparam int CL_MAX = 3;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } sdr_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
   import sdr_rw_pkg::*;
(
   input  sdr_cmd_e cmd,
   output logic     cs_n,
   output logic     ras_n,
   output logic     cas_n,
   output logic     we_n
);
   always_comb begin
      cs_n  = 1'b0;
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      case (cmd)
         CMD_READ:  cas_n = 1'b0;
         CMD_WRITE: begin
            cas_n = 1'b0;
            we_n  = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sdr_wbeat_sel.sv
module sdr_wbeat_sel #(
   parameter int DW = 16,
   parameter int NB = 4,
   parameter int SW = $clog2(NB)
) (
   input  logic [NB*DW-1:0] burst,
   input  logic [SW-1:0]    sel,
   output logic [DW-1:0]    beat
);
   logic [DW-1:0] lanes [NB];

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lanes[g] = burst[g*DW +: DW];
   end

   assign beat = lanes[sel];
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
   parameter int DW = 16,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] din,
   output logic          vld,
   output logic [IW-1:0] vidx,
   output logic [DW-1:0] vdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld   <= 1'b0;
         vidx  <= '0;
         vdata <= '0;
      end else begin
         vld <= take;
         if (take) begin
            vidx  <= idx;
            vdata <= din;
         end
      end
   end
endmodule

// File: rtl/sdr_rw_seq.sv
module sdr_rw_seq
   import sdr_rw_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cas_lat,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [BEATS*DW-1:0]  req_wdata,
   output logic                 req_ready,
   output logic                 sd_cs_n,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic [AW-1:0]        sd_addr,
   output logic                 sd_dqm,
   input  logic [DW-1:0]        dq_in,
   output logic [DW-1:0]        dq_out,
   output logic                 dq_oe,
   output logic                 rd_valid,
   output logic [1:0]           rd_beat,
   output logic [DW-1:0]        rd_data
);
   localparam int NB   = BEATS;
   localparam int BW   = $clog2(NB);
   localparam int KMAX = CL_MAX + NB;
   localparam int KW   = $clog2(KMAX + 1);

   if (DW < 1) begin : g_bad_dw
      $error("sdr_rw_seq: DW must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("sdr_rw_seq: AW must be at least 1");
   end
   if (BW != 2) begin : g_bad_nb
      $error("sdr_rw_seq: burst must be four beats");
   end

   seq_st_e          st;
   logic [KW-1:0]    k;
   logic [1:0]       cl_q;
   logic             pend;
   logic [AW-1:0]    rd_a, wr_a;
   logic [NB*DW-1:0] wr_d;
   logic [1:0]       icnt;
   logic [BW-1:0]    wb;
   logic             dqm_d1, dqm_d2;

   logic [KW-1:0]    cl_k, k_last, k_arm_max;
   logic [1:0]       cl_eff;
   logic             acc, go_now, beat_ok;
   logic [BW-1:0]    beat_idx;
   sdr_cmd_e         cmd;

   assign cl_k      = KW'(cl_q);
   assign k_last    = cl_k + KW'(NB);
   assign k_arm_max = cl_k + KW'(1);
   assign cl_eff    = (cas_lat == 2'd0) ? 2'd1 : cas_lat;

   always_comb begin
      req_ready = (st == ST_IDLE) ||
                  ((st == ST_RD) && !pend && req_write && (k < k_last));
      acc       = req_valid && req_ready;
      go_now    = (st == ST_RD) && pend && (icnt == 2'd0) && (k <= k_arm_max);
      sd_dqm    = go_now || (icnt != 2'd0);
      beat_ok   = (st == ST_RD) && (k >= cl_k) && (k <= cl_k + KW'(NB - 1)) && !dqm_d2;
      beat_idx  = BW'(k - cl_k);
      if ((st == ST_RD) && (k == '0))       cmd = CMD_READ;
      else if ((st == ST_WR) && (wb == '0)) cmd = CMD_WRITE;
      else                                  cmd = CMD_NOP;
      case (cmd)
         CMD_READ:  sd_addr = rd_a;
         CMD_WRITE: sd_addr = wr_a;
         default:   sd_addr = '0;
      endcase
      dq_oe = (st == ST_WR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         k      <= '0;
         cl_q   <= 2'd1;
         pend   <= 1'b0;
         rd_a   <= '0;
         wr_a   <= '0;
         wr_d   <= '0;
         icnt   <= 2'd0;
         wb     <= '0;
         dqm_d1 <= 1'b0;
         dqm_d2 <= 1'b0;
      end else begin
         dqm_d1 <= sd_dqm;
         dqm_d2 <= dqm_d1;
         case (st)
            ST_IDLE: begin
               if (acc) begin
                  if (req_write) begin
                     wr_a <= req_addr;
                     wr_d <= req_wdata;
                     wb   <= '0;
                     st   <= ST_WR;
                  end else begin
                     rd_a <= req_addr;
                     cl_q <= cl_eff;
                     k    <= '0;
                     st   <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               k <= k + KW'(1);
               if (acc) begin
                  pend <= 1'b1;
                  wr_a <= req_addr;
                  wr_d <= req_wdata;
               end
               if (go_now) begin
                  icnt <= 2'd1;
               end else if (icnt == 2'd1) begin
                  icnt <= 2'd2;
               end else if (icnt == 2'd2) begin
                  icnt <= 2'd0;
                  pend <= 1'b0;
                  wb   <= '0;
                  st   <= ST_WR;
               end else if (k == k_last) begin
                  if (pend) begin
                     pend <= 1'b0;
                     wb   <= '0;
                     st   <= ST_WR;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_WR: begin
               wb <= wb + BW'(1);
               if (wb == BW'(NB - 1)) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   sdr_cmd_enc u_enc (
      .cmd   (cmd),
      .cs_n  (sd_cs_n),
      .ras_n (sd_ras_n),
      .cas_n (sd_cas_n),
      .we_n  (sd_we_n)
   );

   sdr_wbeat_sel #(.DW(DW), .NB(NB), .SW(BW)) u_wsel (
      .burst (wr_d),
      .sel   (wb),
      .beat  (dq_out)
   );

   sdr_rd_capture #(.DW(DW), .IW(BW)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (beat_ok),
      .idx   (beat_idx),
      .din   (dq_in),
      .vld   (rd_valid),
      .vidx  (rd_beat),
      .vdata (rd_data)
   );
endmodule

// File: rtl/sdr_rw_seq_chk.sv
module sdr_rw_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sd_cs_n,
   input logic sd_ras_n,
   input logic sd_cas_n,
   input logic sd_we_n,
   input logic sd_dqm,
   input logic dq_oe,
   input logic req_ready,
   input logic rd_valid
);
   logic is_wr;
   assign is_wr = !sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n;

   // R2: only NOP, READ or WRITE encodings appear
   p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cs_n && sd_ras_n && (sd_cas_n -> sd_we_n));

   // R5: mask is released in the WRITE cycle
   p_dqm_clear_at_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> !sd_dqm);

   // R4: a mask run that ends at a WRITE lasted three cycles
   p_dqm_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && $past(sd_dqm)) |-> ($past(sd_dqm, 2) && $past(sd_dqm, 3)));

   // R8: driving starts only with a WRITE command
   p_oe_starts_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> is_wr);

   // R10: no request taken while write beats are driven
   p_no_ready_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !req_ready);

   // R9: no read beat reported that was sampled while driving
   p_no_capture_while_driving_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(dq_oe));
endmodule

bind sdr_rw_seq sdr_rw_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_dqm    (sd_dqm),
   .dq_oe     (dq_oe),
   .req_ready (req_ready),
   .rd_valid  (rd_valid)
);

// File: tb/sdr_rw_seq_test.sv
`timescale 1ns/1ps
module sdr_rw_seq_test;
   localparam int DW = 16;
   localparam int AW = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      cas_lat = 2'd1;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [4*DW-1:0] req_wdata = '0;
   logic            req_ready;
   logic            sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [AW-1:0]   sd_addr;
   logic            sd_dqm;
   logic [DW-1:0]   dq_in = 16'hF00D;
   logic [DW-1:0]   dq_out;
   logic            dq_oe;
   logic            rd_valid;
   logic [1:0]      rd_beat;
   logic [DW-1:0]   rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   sdr_rw_seq #(.DW(DW), .AW(AW)) uut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // 0 NOP, 1 READ, 2 WRITE, 3 other
   function automatic int pin_cmd();
      if (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)   return 0;
      if (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n)  return 1;
      if (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n) return 2;
      return 3;
   endfunction

   // d < 0: read only; otherwise a write is presented in READ cycle + d
   task automatic run_trial(input int L, input int d, input int id);
      int  w;
      bit  intr;
      int  nv;
      bit  wv;
      bit  acc_prev;
      int  tmax;
      logic [AW-1:0] ra, wa;
      bit  masked [0:31];
      ra = AW'(12'h100 + id);
      wa = AW'(12'h800 + id);
      intr = 1'b0;
      w = -100;
      if (d >= 0) begin
         if (d <= L) begin
            w = d + 4;
            intr = 1'b1;
         end else if (d <= L + 3) begin
            w = L + 5;
         end else begin
            w = ((d > L + 5) ? d : L + 5) + 1;
         end
      end
      nv = 4;
      if (intr) begin
         nv = d + 3 - L;
         if (nv < 0) nv = 0;
      end
      tmax = L + 11;
      for (int i = 0; i < 32; i++) masked[i] = 1'b0;

      @(negedge clk);
      cas_lat   = 2'(L);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = ra;
      #1;
      chk(req_ready == 1'b1, "R10", "ready in idle", longint'(req_ready), 1);
      wv = 1'b0;
      acc_prev = 1'b0;
      for (int t = 0; t <= tmax; t++) begin
         int ec;
         @(negedge clk);
         if (t == 0) req_valid = 1'b0;
         if (wv && acc_prev) begin
            wv = 1'b0;
            req_valid = 1'b0;
         end
         if (d >= 0 && t == d) begin
            wv = 1'b1;
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = wa;
            for (int b = 0; b < 4; b++)
               req_wdata[b*DW +: DW] = DW'((id << 8) | (8'h50 + b));
         end
         if (d < 0 && t == 1) begin
            req_valid = 1'b1;
            req_write = 1'b0;
            #1;
            chk(req_ready == 1'b0, "R10", "read held during read", longint'(req_ready), 0);
            req_valid = 1'b0;
         end
         dq_in = (t >= L && t <= L + 3) ? DW'((id << 8) | (8'hA0 + t - L)) : 16'hF00D;
         #1;
         acc_prev = wv && req_ready;
         if (t >= 2 && t - 2 < 32) masked[t] = 1'b0;
         // command and address
         ec = (t == 0) ? 1 : ((t == w) ? 2 : 0);
         chk(pin_cmd() == ec, (ec == 2 && !intr) ? "R7" : (ec == 2 ? "R4" : "R2"),
             $sformatf("cmd L=%0d d=%0d t=%0d", L, d, t), pin_cmd(), ec);
         if (ec == 1) chk(sd_addr == ra, "R2", "read address", sd_addr, ra);
         else if (ec == 2) chk(sd_addr == wa, "R2", "write address", sd_addr, wa);
         else chk(sd_addr == '0, "R2", "nop address", sd_addr, 0);
         // mask
         chk(sd_dqm == (intr && t >= d + 1 && t <= d + 3), intr ? "R4" : "R5",
             $sformatf("dqm L=%0d d=%0d t=%0d", L, d, t),
             sd_dqm, (intr && t >= d + 1 && t <= d + 3));
         if (t < 30) masked[t + 2] = sd_dqm;
         // write beats
         chk(dq_oe == (t >= w && t <= w + 3), "R8",
             $sformatf("oe L=%0d d=%0d t=%0d", L, d, t), dq_oe, (t >= w && t <= w + 3));
         if (t >= w && t <= w + 3)
            chk(dq_out == DW'((id << 8) | (8'h50 + t - w)), "R8", "write beat",
                dq_out, DW'((id << 8) | (8'h50 + t - w)));
         // no overlap with live read data
         if (t >= L && t <= L + 3 && t < w && !masked[t])
            chk(dq_oe == 1'b0, "R9", "drive while memory drives", dq_oe, 0);
         // read beats
         begin
            int  i;
            bit  ev;
            i  = t - L - 1;
            ev = (i >= 0 && i < nv);
            chk(rd_valid == ev, intr ? "R6" : "R3",
                $sformatf("rd_valid L=%0d d=%0d t=%0d", L, d, t), rd_valid, ev);
            if (ev) begin
               chk(rd_beat == 2'(i), "R3", "beat index", rd_beat, i);
               chk(rd_data == DW'((id << 8) | (8'hA0 + i)), "R3", "beat data",
                   rd_data, DW'((id << 8) | (8'hA0 + i)));
            end
         end
      end
      req_valid = 1'b0;
      req_write = 1'b0;
      dq_in = 16'hF00D;
   endtask

   initial begin
      int id;
      repeat (3) @(negedge clk);
      chk(pin_cmd() == 0, "R1", "cmd in reset", pin_cmd(), 0);
      chk(sd_dqm == 1'b0, "R1", "dqm in reset", sd_dqm, 0);
      chk(dq_oe == 1'b0, "R1", "oe in reset", dq_oe, 0);
      chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pin_cmd() == 0 && !sd_dqm && !dq_oe && !rd_valid, "R1", "idle after reset",
          {pin_cmd(), sd_dqm, dq_oe, rd_valid}, 0);
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      id = 1;
      for (int L = 1; L <= 3; L++) begin
         for (int d = -1; d <= L + 5; d++) begin
            run_trial(L, d, id);
            id++;
         end
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule